// File: doc/BRIEF.md
# Interrupt Poll Command Handler

This block gives an eight-level interrupt controller a polled service path. When software writes a command of the operation-control kind with its poll bit set, the handler arms itself. The next register read is then treated as an interrupt acknowledge rather than a plain register access. That read returns a status byte. The byte carries a flag that says whether anything was pending and the binary number of the most urgent pending level. In the same cycle the handler pulses the in-service update for that level.

Between the arming write and the acknowledging read, the masked request vector is held at the value it had on the arming edge. While the handler is armed, the controller's interrupt line to the processor is held low. Urgency follows a rotation pointer. The pointer names the least urgent level, and the level just above it in circular order ranks first. A parameter can instead select fixed ranking, in which level 0 ranks first. Vector generation is not part of this block.

Top module: `pch_poll_unit`

## Requirements
- R1: While reset is low and after its release, the handler is disarmed, rd_data reads 0x00, isr_set is all zero, and int_out follows int_in.
- R2: A write with wr_data[4:3] = 2'b01 and wr_data[2] = 1 arms the handler. A write with wr_data[2] = 0, or with any other value in wr_data[4:3], leaves the arm state unchanged.
- R3: On the first read after arming, rd_data takes the poll byte one clock after the rd_en cycle. Bit 7 is 1 when a level was pending, bits 2:0 give the level number, and bits 6:3 are 0.
- R4: In the same clock as that rd_data update, isr_set pulses high for one cycle on exactly the bit of the reported level.
- R5: With ROTATE_EN = 1, the level one above bottom_sel (modulo 8) ranks first, and urgency falls in ascending circular order. With ROTATE_EN = 0, level 0 ranks first.
- R6: If no unmasked level is pending at the poll read, the byte is 0x00 and isr_set stays all zero.
- R7: The pending set used by a poll read is irq_req AND NOT irq_mask, taken at the clock edge of the arming write. Changes to irq_req after that edge do not affect the byte.
- R8: A poll read disarms the handler. Any read while disarmed loads reg_rdata into rd_data one clock later and leaves isr_set at zero.
- R9: A second poll write before the read does not queue a second poll. Only one read is converted.
- R10: While the handler is armed, int_out is 0. Otherwise int_out equals int_in.
- R11: A read in the same cycle as an arming write while disarmed is a plain read, and the handler is armed afterwards. A read in the same cycle as a poll write while armed returns the poll byte, and the handler stays armed with a new sample taken at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Register read strobe |
| reg_rdata | input | 8 | Normal register contents returned on plain reads |
| rd_data | output | 8 | Read data, updated one clock after rd_en |
| irq_req | input | 8 | Request vector, one bit per level |
| irq_mask | input | 8 | Mask vector, 1 blocks the level |
| bottom_sel | input | 3 | Least-urgent level for rotating ranking |
| isr_set | output | 8 | One-cycle in-service set pulse, one-hot |
| int_in | input | 1 | Interrupt request from the controller core |
| int_out | output | 1 | Interrupt line to the processor, gated off while armed |

## Verification
A read and a poll command write can arrive on the same clock. Whether that read is a plain read or the acknowledge depends on whether the handler was already armed. The bench drives both strobes in one cycle, first from the disarmed state and then from the armed state. In each case it checks the returned byte and isr_set, and then issues a follow-up read to show whether the handler is left armed. In the armed case the request vector is changed before the combined cycle, so the follow-up byte must reflect the new sample and not the older frozen one.

// File: rtl/pch_pkg.sv
package pch_pkg;
   localparam int unsigned SEL_HI   = 4;
   localparam int unsigned SEL_LO   = 3;
   localparam int unsigned POLL_POS = 2;
   localparam logic [1:0]  OCW3_TAG = 2'b01;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_POLL  = 2'd1,
      CMD_OTHER = 2'd2
   } cmd_kind_t;
endpackage

// File: rtl/pch_cmd_dec.sv
module pch_cmd_dec #(
   parameter int unsigned DW = 8
) (
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output pch_pkg::cmd_kind_t kind
);
   import pch_pkg::*;

   if (DW <= SEL_HI) begin : g_bad_dw
      $error("pch_cmd_dec: DW too narrow for the command select field");
   end

   logic is_ctl3;
   assign is_ctl3 = (wr_data[SEL_HI:SEL_LO] == OCW3_TAG);

   always_comb begin
      if (!wr_en)                          kind = CMD_NONE;
      else if (is_ctl3 && wr_data[POLL_POS]) kind = CMD_POLL;
      else                                  kind = CMD_OTHER;
   end
endmodule

// File: rtl/pch_prio_rot.sv
module pch_prio_rot #(
   parameter int unsigned N_LVL     = 8,
   parameter int unsigned CODE_W    = $clog2(N_LVL),
   parameter bit          ROTATE_EN = 1'b1
) (
   input  logic [N_LVL-1:0]  pend,
   input  logic [CODE_W-1:0] bottom,
   output logic              any,
   output logic [CODE_W-1:0] code
);
   logic [CODE_W-1:0] start;

   if (ROTATE_EN) begin : g_rot
      assign start = bottom + CODE_W'(1);
   end else begin : g_fixed
      logic [CODE_W-1:0] unused_bottom;
      assign unused_bottom = bottom;
      assign start = '0;
   end

   always_comb begin
      logic [CODE_W-1:0] idx;
      any  = 1'b0;
      code = '0;
      for (int i = 0; i < int'(N_LVL); i++) begin
         idx = start + CODE_W'(i);
         if (!any && pend[idx]) begin
            any  = 1'b1;
            code = idx;
         end
      end
   end
endmodule

// File: rtl/pch_arm_ctl.sv
module pch_arm_ctl #(
   parameter int unsigned N_LVL = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pch_pkg::cmd_kind_t kind,
   input  logic             rd_en,
   input  logic [N_LVL-1:0] req_live,
   output logic             armed,
   output logic [N_LVL-1:0] req_q
);
   import pch_pkg::*;

   logic sample_en;
   assign sample_en = !armed || rd_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         req_q <= '0;
      end else begin
         if (kind == CMD_POLL)  armed <= 1'b1;
         else if (rd_en)        armed <= 1'b0;
         if (sample_en)         req_q <= req_live;
      end
   end
endmodule

// File: rtl/pch_poll_unit.sv
module pch_poll_unit #(
   parameter int unsigned N_LVL     = 8,
   parameter int unsigned DW        = 8,
   parameter int unsigned FLAG_POS  = 7,
   parameter bit          ROTATE_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [DW-1:0]            wr_data,
   input  logic                     rd_en,
   input  logic [DW-1:0]            reg_rdata,
   output logic [DW-1:0]            rd_data,
   input  logic [N_LVL-1:0]         irq_req,
   input  logic [N_LVL-1:0]         irq_mask,
   input  logic [$clog2(N_LVL)-1:0] bottom_sel,
   output logic [N_LVL-1:0]         isr_set,
   input  logic                     int_in,
   output logic                     int_out
);
   import pch_pkg::*;

   localparam int unsigned CODE_W = $clog2(N_LVL);

   if (N_LVL != (1 << CODE_W)) begin : g_bad_lvl
      $error("pch_poll_unit: N_LVL must be a power of two");
   end
   if (FLAG_POS >= DW || FLAG_POS < CODE_W) begin : g_bad_flag
      $error("pch_poll_unit: FLAG_POS must lie above the code field and inside DW");
   end

   cmd_kind_t         kind;
   logic              armed;
   logic [N_LVL-1:0]  req_q;
   logic              any;
   logic [CODE_W-1:0] code;
   logic [DW-1:0]     poll_byte;

   pch_cmd_dec #(.DW(DW)) u_dec (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .kind    (kind)
   );

   pch_arm_ctl #(.N_LVL(N_LVL)) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .rd_en    (rd_en),
      .req_live (irq_req & ~irq_mask),
      .armed    (armed),
      .req_q    (req_q)
   );

   pch_prio_rot #(.N_LVL(N_LVL), .CODE_W(CODE_W), .ROTATE_EN(ROTATE_EN)) u_prio (
      .pend   (req_q),
      .bottom (bottom_sel),
      .any    (any),
      .code   (code)
   );

   always_comb begin
      poll_byte                = '0;
      poll_byte[FLAG_POS]      = any;
      poll_byte[CODE_W-1:0]    = code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         isr_set <= '0;
      end else begin
         isr_set <= '0;
         if (rd_en) begin
            if (armed) begin
               rd_data <= poll_byte;
               if (any) isr_set <= N_LVL'(1) << code;
            end else begin
               rd_data <= reg_rdata;
            end
         end
      end
   end

   assign int_out = int_in & ~armed;
endmodule

// File: rtl/pch_poll_chk.sv
module pch_poll_chk #(
   parameter int unsigned N_LVL    = 8,
   parameter int unsigned DW       = 8,
   parameter int unsigned FLAG_POS = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [DW-1:0]    wr_data,
   input logic             rd_en,
   input logic [DW-1:0]    rd_data,
   input logic [N_LVL-1:0] isr_set,
   input logic             int_out,
   input logic             armed,
   input logic [N_LVL-1:0] req_q
);
   localparam int unsigned CODE_W = $clog2(N_LVL);

   logic poll_wr;
   assign poll_wr = wr_en && (wr_data[4:3] == 2'b01) && wr_data[2];

   // R2
   arm_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_wr |=> armed);

   // R4
   isr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_set));

   // R4
   isr_needs_poll_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|isr_set) |-> $past(rd_en && armed));

   // R3
   flag_matches_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && armed) |-> (rd_data[FLAG_POS] == (|isr_set)));

   // R3
   code_matches_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|isr_set) |-> (isr_set[rd_data[CODE_W-1:0]] && rd_data[FLAG_POS-1:CODE_W] == '0));

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(armed) && !$past(rd_en)) |-> $stable(req_q));

   // R8
   disarm_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && rd_en && !poll_wr) |=> !armed);

   // R10
   int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !int_out);
endmodule

bind pch_poll_unit pch_poll_chk #(.N_LVL(N_LVL), .DW(DW), .FLAG_POS(FLAG_POS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .isr_set (isr_set),
   .int_out (int_out),
   .armed   (armed),
   .req_q   (req_q)
);

// File: tb/pch_poll_unit_test.sv
module pch_poll_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] reg_rdata = 8'h5A;
   logic [7:0] rd_data;
   logic [7:0] irq_req = '0;
   logic [7:0] irq_mask = '0;
   logic [2:0] bottom_sel = 3'd7;
   logic [7:0] isr_set;
   logic       int_in = 1'b0;
   logic       int_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pch_poll_unit uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .reg_rdata(reg_rdata), .rd_data(rd_data),
      .irq_req(irq_req), .irq_mask(irq_mask), .bottom_sel(bottom_sel),
      .isr_set(isr_set), .int_in(int_in), .int_out(int_out)
   );

   localparam logic [7:0] POLL = 8'h0C;

   // {req, mask, late_req, bottom, expected byte}
   localparam int NV = 9;
   localparam logic [39:0] VEC [NV] = '{
      {8'h24, 8'h00, 8'h24, 8'd7, 8'h82},
      {8'h24, 8'h00, 8'h00, 8'd2, 8'h85},
      {8'h24, 8'h00, 8'hFF, 8'd5, 8'h82},
      {8'h81, 8'h00, 8'h81, 8'd0, 8'h87},
      {8'h81, 8'h80, 8'h81, 8'd0, 8'h80},
      {8'hFF, 8'hFF, 8'hFF, 8'd3, 8'h00},
      {8'h00, 8'h00, 8'hFF, 8'd7, 8'h00},
      {8'h10, 8'h00, 8'h01, 8'd7, 8'h84},
      {8'h08, 8'h00, 8'h00, 8'd3, 8'h83}
   };

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] isr_of(logic [7:0] b);
      return b[7] ? (8'h01 << b[2:0]) : 8'h00;
   endfunction

   task automatic do_write(logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic do_both(logic [7:0] d);
      @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_data = d;
      @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      int_in = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rd_data in reset", rd_data, 8'h00);
      check("R1 isr_set in reset", isr_set, 8'h00);
      check("R1 int_out in reset", {7'd0, int_out}, 8'h01);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_data after reset", rd_data, 8'h00);

      // R3 R4 R5 R6 R7 vector table
      for (int i = 0; i < NV; i++) begin
         irq_req = VEC[i][39:32]; irq_mask = VEC[i][31:24];
         bottom_sel = VEC[i][10:8];
         do_write(POLL);
         irq_req = VEC[i][23:16];
         do_read();
         check($sformatf("R3 R5 R6 R7 vec%0d byte", i), rd_data, VEC[i][7:0]);
         check($sformatf("R4 vec%0d isr_set", i), isr_set, isr_of(VEC[i][7:0]));
         @(negedge clk);
         check($sformatf("R4 vec%0d isr pulse ends", i), isr_set, 8'h00);
      end
      irq_mask = '0;

      // R8 plain read, disarm after one poll read
      reg_rdata = 8'h3C; irq_req = 8'h02; bottom_sel = 3'd7;
      do_read();
      check("R8 plain read", rd_data, 8'h3C);
      check("R8 plain read isr", isr_set, 8'h00);
      do_write(POLL); do_read();
      check("R8 poll read", rd_data, 8'h81);
      do_read();
      check("R8 second read plain", rd_data, 8'h3C);
      check("R8 second read isr", isr_set, 8'h00);

      // R2 non-poll writes
      do_write(8'h08); do_read();
      check("R2 P=0 does not arm", rd_data, 8'h3C);
      do_write(8'h1C); do_read();
      check("R2 wrong select does not arm", rd_data, 8'h3C);
      do_write(8'h04); do_read();
      check("R2 select 00 does not arm", rd_data, 8'h3C);

      // R9 double arm
      do_write(POLL); do_write(POLL); do_read();
      check("R9 one poll byte", rd_data, 8'h81);
      do_read();
      check("R9 no second poll", rd_data, 8'h3C);

      // R10 interrupt gating
      int_in = 1'b1; @(negedge clk);
      check("R10 int_out disarmed", {7'd0, int_out}, 8'h01);
      do_write(POLL);
      check("R10 int_out armed", {7'd0, int_out}, 8'h00);
      do_read();
      check("R10 int_out after read", {7'd0, int_out}, 8'h01);

      // R11 read with poll write while disarmed
      irq_req = 8'h40;
      do_both(POLL);
      check("R11 disarmed combo is plain", rd_data, 8'h3C);
      check("R11 disarmed combo isr", isr_set, 8'h00);
      check("R11 disarmed combo arms", {7'd0, int_out}, 8'h00);
      irq_req = 8'h20;
      do_read();
      check("R11 sample at arming edge", rd_data, 8'h86);

      // R11 read with poll write while armed
      irq_req = 8'h01;
      do_write(POLL);
      irq_req = 8'h08;
      do_both(POLL);
      check("R11 armed combo poll byte", rd_data, 8'h80);
      check("R11 armed combo isr", isr_set, 8'h01);
      irq_req = 8'h00;
      do_read();
      check("R11 rearmed fresh sample", rd_data, 8'h83);
      do_read();
      check("R11 disarmed after", rd_data, 8'h3C);

      summary();
   end
endmodule